// File: doc/BRIEF.md
# Watchdog Timer with Programmable Output Shaping

A watchdog timer that counts down a programmed start value in whole seconds or whole minutes. Its time base is a 1 kHz tick-enable input, which an internal prescaler divides down. Host software works through a two-register port. The control register holds the enable, the output mode, the count unit, the active polarity, the pulse-width code and a sticky timeout flag. The range register holds the start value of the countdown.

When the count runs out, the block sets the timeout flag and asserts the watchdog pin. In level mode the pin stays asserted until software clears the flag or disables the timer. In pulse mode the pin is asserted for one pulse of selectable width. Software keeps the watchdog from firing by rewriting the range register while the timer runs. A range of zero turns off the timeout entirely.

Top module: `wdt_shaper`

## Requirements
- R1: After reset the control register (select 0) and the range register (select 1) both read 0. Control bit 7 always reads 0, even after a write of 1. With the default low polarity, the pin is inactive and therefore high.
- R2: Setting control bit 5 (enable) while it is clear loads the range value into the counter. With range N and the seconds unit, the timeout flag (control bit 6) reads 1 exactly N*SEC_DIV tick_ms pulses after that write, and not earlier.
- R3: In level mode (control bit 4 = 0) the pin holds its active level from the timeout onward, for as long as the flag is set and the timer is enabled.
- R4: Writing control with bit 6 = 1 clears the timeout flag. Writing bit 6 = 0 leaves the flag unchanged. A timeout in the same cycle as a clear sets the flag.
- R5: A range write while the timer is enabled reloads the counter with the written value and restarts the prescaler, which delays the timeout.
- R6: A range of 0 never causes a timeout.
- R7: Clearing the enable bit stops the countdown and returns the pin to its inactive level at once. The timeout flag keeps its value.
- R8: Control bit 2 sets the polarity. When bit 2 = 1 the pin is high while asserted and low while inactive. When bit 2 = 0 the pin is low while asserted and high while inactive.
- R9: In pulse mode (control bit 4 = 1) a timeout asserts the pin for exactly PW0, PW1, PW2 or PW3_SEC*SEC_DIV tick_ms pulses, selected by bits 1:0 = 00, 01, 10 and 11. By default these are 1 ms, 20 ms, 100 ms and 4 s. The flag stays set after the pulse ends.
- R10: When control bit 3 = 1 the count unit is minutes, so range N times out after N*SEC_DIV*MIN_DIV tick_ms pulses.
- R11: The countdown advances only on cycles with tick_ms high. Cycles without a tick make no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | 1 kHz tick enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 range |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 range |
| rd_data | output | 8 | Read data (combinational) |
| wdt_out | output | 1 | Watchdog pin |

## Verification
The bench places its samples one tick before and one tick after the expected timeout. A counter that is off by one in the prescaler or in the reload therefore fails on one side of the boundary. It measures every pulse width at its first and last active cycle and at the cycle after. A width decode that is swapped or one cycle long shows up as a wrong level. It writes the flag's clear bit as 0, disables the timer after a timeout and uses a range of 0. A design that clears the flag on any write, leaves the pin asserted after disable, or wraps the counter from 0 would report a timeout or a pin level the bench does not expect. The kick and tick-gating scenarios catch a design that keeps counting from the old value or that counts clock cycles instead of ticks.

// File: rtl/wdt_shaper.sv
module wdt_shaper #(
  parameter int SEC_DIV = 1000,
  parameter int MIN_DIV = 60,
  parameter int PW0     = 1,
  parameter int PW1     = 20,
  parameter int PW2     = 100,
  parameter int PW3_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       wdt_out
);
  localparam int PW3 = PW3_SEC * SEC_DIV;
  localparam int MSW = $clog2(SEC_DIV + 1);
  localparam int SW  = $clog2(MIN_DIV + 1);
  localparam int PCW = $clog2(PW0 + PW1 + PW2 + PW3 + 1);

  logic sts, en, pmode, umin, ahigh;
  logic [1:0] pw;
  logic [7:0] rng, cnt;
  logic [MSW-1:0] ms_cnt;
  logic [SW-1:0] s_cnt;
  logic pact;
  logic [PCW-1:0] pcnt, pw_len;

  wire ctrl_wr  = wr_en & ~wr_sel;
  wire rng_wr   = wr_en & wr_sel;
  wire load     = (ctrl_wr & wr_data[5] & ~en) | (rng_wr & en);
  wire [7:0] load_val = rng_wr ? wr_data : rng;
  wire sec_tick = en & tick_ms & (ms_cnt == MSW'(SEC_DIV - 1));
  wire min_tick = sec_tick & (s_cnt == SW'(MIN_DIV - 1));
  wire unit_tick = umin ? min_tick : sec_tick;
  wire expire   = en & ~load & unit_tick & (cnt == 8'd1);
  wire asserted = en & (pmode ? pact : sts);

  always_comb begin
    case (pw)
      2'b00:   pw_len = PCW'(PW0);
      2'b01:   pw_len = PCW'(PW1);
      2'b10:   pw_len = PCW'(PW2);
      default: pw_len = PCW'(PW3);
    endcase
  end

  assign rd_data = rd_sel ? rng : {1'b0, sts, en, pmode, umin, ahigh, pw};
  assign wdt_out = asserted ? ahigh : ~ahigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, pmode, umin, ahigh, pw} <= '0;
      rng <= '0;
    end else begin
      if (ctrl_wr) {en, pmode, umin, ahigh, pw} <= wr_data[5:0];
      if (rng_wr) rng <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= 1'b0;
    else if (expire) sts <= 1'b1;
    else if (ctrl_wr && wr_data[6]) sts <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_cnt <= '0;
      s_cnt  <= '0;
      cnt    <= '0;
    end else if (load) begin
      ms_cnt <= '0;
      s_cnt  <= '0;
      cnt    <= load_val;
    end else if (!en) begin
      ms_cnt <= '0;
      s_cnt  <= '0;
    end else begin
      if (tick_ms) ms_cnt <= sec_tick ? '0 : ms_cnt + 1'b1;
      if (sec_tick) s_cnt <= min_tick ? '0 : s_cnt + 1'b1;
      if (unit_tick && cnt != 8'd0) cnt <= cnt - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pact <= 1'b0;
      pcnt <= '0;
    end else if (!en) begin
      pact <= 1'b0;
    end else if (expire && pmode) begin
      pact <= 1'b1;
      pcnt <= '0;
    end else if (pact && tick_ms) begin
      if (pcnt == pw_len - 1'b1) pact <= 1'b0;
      else pcnt <= pcnt + 1'b1;
    end
  end

  assert_sts_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sts && !(ctrl_wr && wr_data[6]) |=> sts);
  assert_zero_no_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0) && !load |=> !$rose(sts));
  assert_off_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> wdt_out == ~ahigh);
  assert_kick_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rng_wr && en |=> cnt == $past(wr_data));
  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pact |-> pcnt < pw_len);
endmodule

// File: tb/sim_wdt_shaper.sv
module sim_wdt_shaper;
  localparam int SD = 20;
  localparam int MD = 3;
  logic clk = 0, rst_n = 0, tick_ms = 1, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic wdt_out;
  int checks = 0, fails = 0;

  wdt_shaper #(.SEC_DIV(SD), .MIN_DIV(MD)) u0 (
    .clk, .rst_n, .tick_ms, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data, .wdt_out);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic sts_now();
    return u0.rd_data[6];
  endfunction

  task automatic rd_sts(output logic s);
    rd_sel = 0; #0.1; s = rd_data[6];
  endtask

  task automatic t_reset();
    rd_sel = 0; #0.1; chk("R1 ctrl reset", rd_data, 8'h00);
    rd_sel = 1; #0.1; chk("R1 range reset", rd_data, 8'h00);
    chk("R1 pin idle", wdt_out, 1);
    wr(0, 8'h80); rd_sel = 0; #0.1; chk("R1 bit7 reads 0", rd_data, 8'h00);
  endtask

  task automatic t_level();
    logic s;
    wr(1, 8'd3); wr(0, 8'h20);
    wait_n(3*SD - 1); rd_sts(s); chk("R2 no early timeout", s, 0);
    chk("R3 pin idle before", wdt_out, 1);
    wait_n(1); rd_sts(s); chk("R2 timeout on time", s, 1);
    chk("R3 pin asserted low", wdt_out, 0);
    wait_n(50); chk("R3 pin held", wdt_out, 0);
    wr(0, 8'h20); rd_sts(s); chk("R4 write 0 no effect", s, 1);
    chk("R4 pin still asserted", wdt_out, 0);
    wr(0, 8'h60); rd_sts(s); chk("R4 write 1 clears", s, 0);
    chk("R4 pin released", wdt_out, 1);
    wait_n(100); rd_sts(s); chk("R6 expired counter idle", s, 0);
    wr(0, 8'h40);
  endtask

  task automatic t_kick();
    logic s;
    wr(1, 8'd2); wr(0, 8'h20);
    wait_n(30); wr(1, 8'd2);
    wait_n(2*SD - 1); rd_sts(s); chk("R5 kick delays timeout", s, 0);
    wait_n(1); rd_sts(s); chk("R5 timeout after kick", s, 1);
    wr(0, 8'h00); chk("R7 disable releases pin", wdt_out, 1);
    rd_sts(s); chk("R7 status kept", s, 1);
    wr(0, 8'h40);
  endtask

  task automatic t_zero();
    logic s;
    wr(1, 8'd0); wr(0, 8'h20);
    wait_n(10*SD); rd_sts(s); chk("R6 range 0 never fires", s, 0);
    chk("R6 pin idle", wdt_out, 1);
    wr(0, 8'h40);
  endtask

  task automatic t_disable_stop();
    logic s;
    wr(1, 8'd1); wr(0, 8'h20); wait_n(SD/2);
    wr(0, 8'h00); wait_n(3*SD); rd_sts(s); chk("R7 disabled stops count", s, 0);
  endtask

  task automatic t_pulse(input logic [1:0] code, input int w);
    logic s;
    wr(0, 8'h40); wr(1, 8'd1); wr(0, 8'h04);
    chk($sformatf("R8 idle low code%0d", code), wdt_out, 0);
    wr(0, 8'h34 | code);
    wait_n(SD - 1); chk("R9 before pulse", wdt_out, 0);
    wait_n(1); chk($sformatf("R9 pulse start code%0d", code), wdt_out, 1);
    wait_n(w - 1); chk($sformatf("R9 pulse last code%0d", code), wdt_out, 1);
    wait_n(1); chk($sformatf("R9 pulse end code%0d", code), wdt_out, 0);
    rd_sts(s); chk("R9 status after pulse", s, 1);
    wr(0, 8'h40);
  endtask

  task automatic t_minutes();
    logic s;
    wr(1, 8'd1); wr(0, 8'h28);
    wait_n(SD*MD - 1); rd_sts(s); chk("R10 no early minute", s, 0);
    wait_n(1); rd_sts(s); chk("R10 minute timeout", s, 1);
    wr(0, 8'h40);
  endtask

  task automatic t_tick_gate();
    logic s;
    @(negedge clk); tick_ms = 0;
    wr(1, 8'd1); wr(0, 8'h20);
    wait_n(100); rd_sts(s); chk("R11 no ticks no progress", s, 0);
    tick_ms = 1;
    wait_n(SD - 1); rd_sts(s); chk("R11 not yet", s, 0);
    wait_n(1); rd_sts(s); chk("R11 timeout after ticks", s, 1);
    wr(0, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_level();
    t_kick();
    t_zero();
    t_disable_stop();
    t_pulse(2'b00, 1);
    t_pulse(2'b01, 20);
    t_pulse(2'b10, 100);
    t_pulse(2'b11, 4*SD);
    t_minutes();
    t_tick_gate();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule